// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit processor whose instructions are all one word long and word aligned. It holds the current PC in a register. Each cycle it takes a decoded flow-control class, the two register operands that a conditional branch compares, a 16-bit branch offset, a 26-bit jump field and a register value for indirect jumps. From these it works out the address of the next instruction, and it loads that address into the PC at the rising clock edge.

Conditional branches and direct jumps are both measured from the address of the following instruction (PC+4), not from the current PC. A jump-and-link also asks for a write of that following address into the return-address register. A later jump through a register can then return the procedure to its caller. Fetch, the register file and any pipelining sit outside the block. Its link outputs are meant to drive a register-file write port directly.

Top module: `nextpc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC register (`pcQ`) with 0x00000000 at the rising edge, whatever the other inputs are.
- R2: Out of reset, `pcQ` takes the value that `nextPc` showed just before each rising clock edge.
- R3: For `flowKind` 0 (sequential) and for the unused codes 6 and 7, `nextPc` = `pcQ` + 4, wrapping modulo 2^32.
- R4: For `flowKind` 1 (branch-if-equal), `nextPc` is the branch target when `opA` == `opB` and `pcQ` + 4 otherwise.
- R5: For `flowKind` 2 (branch-if-not-equal), `nextPc` is the branch target when `opA` != `opB` and `pcQ` + 4 otherwise.
- R6: The branch target is `pcQ` + 4 plus `branchImm` sign-extended from bit 15 and shifted left by two, wrapping modulo 2^32. Offsets with bit 15 set move backwards.
- R7: For `flowKind` 3 (jump), `nextPc` = {bits 31:28 of `pcQ`+4, `jumpField`, 2'b00}.
- R8: For `flowKind` 4 (jump-and-link), `nextPc` is the same target as in R7. In that cycle `linkWe` is 1, `linkReg` is 31 and `linkVal` = `pcQ` + 4.
- R9: For `flowKind` 5 (jump-register), `nextPc` equals `jumpRegVal` exactly, with no change to its low bits.
- R10: `linkWe` is 0 for every `flowKind` other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| flowKind | input | 3 | Flow class: 0 sequential, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 jump-and-link, 5 jump-register, 6 and 7 sequential |
| opA | input | 32 | First compared register operand |
| opB | input | 32 | Second compared register operand |
| branchImm | input | 16 | Signed branch offset, counted in words |
| jumpField | input | 26 | Jump address field, counted in words |
| jumpRegVal | input | 32 | Register value for jump-register |
| pcQ | output | 32 | Current program counter |
| nextPc | output | 32 | Address loaded into the PC at the next edge |
| linkWe | output | 1 | Return-address write enable |
| linkReg | output | 5 | Index of the register that receives the link (31) |
| linkVal | output | 32 | Return address (PC+4) |

## Verification
The bench sweeps every class code at a set of PCs near the region and wrap boundaries, and it uses both equal and unequal operands for each. A design that measured the branch from PC instead of PC+4 would land one word short. Zero-extending the offset would send a backward branch about 256 KiB forward. Taking the upper jump bits from PC would fail only when PC+4 crosses into a new 256 MiB region, which is why a PC of 0x0FFFFFFC is in the sweep. The bench also checks for a link written on a class other than jump-and-link, unused codes that do not behave as sequential, and a reset that fails to win over a pending jump.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ   = 3'd0,
    FLOW_BEQ   = 3'd1,
    FLOW_BNE   = 3'd2,
    FLOW_JMP   = 3'd3,
    FLOW_JAL   = 3'd4,
    FLOW_JREG  = 3'd5,
    FLOW_RSV6  = 3'd6,
    FLOW_RSV7  = 3'd7
  } flowKind_e;

  typedef struct packed {
    logic takeBranch;
    logic takeJump;
    logic takeReg;
    logic writeLink;
  } flowStrobes_t;

  localparam flowStrobes_t STROBES_SEQ = '{
    takeBranch: 1'b0, takeJump: 1'b0, takeReg: 1'b0, writeLink: 1'b0};

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [2:0]   flowKind,
  input  logic         opsEqual,
  output flowStrobes_t strobes
);

  flowKind_e kindDec;

  always_comb begin
    kindDec = flowKind_e'(flowKind);
  end

  always_comb begin
    strobes = STROBES_SEQ;
    unique case (kindDec)
      FLOW_BEQ:  strobes.takeBranch = opsEqual;
      FLOW_BNE:  strobes.takeBranch = ~opsEqual;
      FLOW_JMP:  strobes.takeJump   = 1'b1;
      FLOW_JAL: begin
        strobes.takeJump  = 1'b1;
        strobes.writeLink = 1'b1;
      end
      FLOW_JREG: strobes.takeReg    = 1'b1;
      FLOW_SEQ, FLOW_RSV6, FLOW_RSV7: strobes = STROBES_SEQ;
      default:   strobes = STROBES_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [XLEN-1:0]  pcCur,
  input  logic [IMM_W-1:0] branchImm,
  input  logic [JF_W-1:0]  jumpField,
  output logic [XLEN-1:0]  pcPlus4,
  output logic [XLEN-1:0]  branchTarget,
  output logic [XLEN-1:0]  jumpTarget
);

  localparam int EXT_W   = XLEN - IMM_W - 2;
  localparam int UPPER_W = XLEN - JF_W - 2;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0] offsetBytes;

  always_comb begin
    pcPlus4 = pcCur + WORD_BYTES;
  end

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb offsetBytes = {{EXT_W{branchImm[IMM_W-1]}}, branchImm, 2'b00};
    end else begin : g_noext
      always_comb offsetBytes = {branchImm[XLEN-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    branchTarget = pcPlus4 + offsetBytes;
  end

  generate
    if (UPPER_W > 0) begin : g_region
      always_comb jumpTarget = {pcPlus4[XLEN-1 -: UPPER_W], jumpField, 2'b00};
    end else begin : g_flat
      always_comb jumpTarget = {jumpField[XLEN-3:0], 2'b00};
    end
  endgenerate

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              IMM_W    = 16,
  parameter int              JF_W     = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  flowStrobes_t     strobes,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [IMM_W-1:0] branchImm,
  input  logic [JF_W-1:0]  jumpField,
  input  logic [XLEN-1:0]  jumpRegVal,
  output logic             opsEqual,
  output logic [XLEN-1:0]  pcQ,
  output logic [XLEN-1:0]  nextPc,
  output logic [XLEN-1:0]  linkVal
);

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] branchTarget;
  logic [XLEN-1:0] jumpTarget;

  npc_target_gen #(
    .XLEN (XLEN),
    .IMM_W(IMM_W),
    .JF_W (JF_W)
  ) tgen_i (
    .pcCur       (pcReg),
    .branchImm   (branchImm),
    .jumpField   (jumpField),
    .pcPlus4     (pcPlus4),
    .branchTarget(branchTarget),
    .jumpTarget  (jumpTarget)
  );

  always_comb begin
    opsEqual = (opA == opB);
  end

  always_comb begin
    nextPc = pcPlus4;
    if (strobes.takeReg) begin
      nextPc = jumpRegVal;
    end else if (strobes.takeJump) begin
      nextPc = jumpTarget;
    end else if (strobes.takeBranch) begin
      nextPc = branchTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= RESET_PC;
    end else begin
      pcReg <= nextPc;
    end
  end

  always_comb begin
    pcQ     = pcReg;
    linkVal = pcPlus4;
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int              XLEN      = 32,
  parameter int              IMM_W     = 16,
  parameter int              JF_W      = 26,
  parameter int              REG_IDX_W = 5,
  parameter logic [XLEN-1:0] RESET_PC  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           flowKind,
  input  logic [XLEN-1:0]      opA,
  input  logic [XLEN-1:0]      opB,
  input  logic [IMM_W-1:0]     branchImm,
  input  logic [JF_W-1:0]      jumpField,
  input  logic [XLEN-1:0]      jumpRegVal,
  output logic [XLEN-1:0]      pcQ,
  output logic [XLEN-1:0]      nextPc,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkReg,
  output logic [XLEN-1:0]      linkVal
);

  import npc_pkg::*;

  localparam logic [REG_IDX_W-1:0] LINK_IDX = {REG_IDX_W{1'b1}};

  flowStrobes_t strobes;
  logic         opsEqual;

  npc_ctrl ctrl_i (
    .flowKind(flowKind),
    .opsEqual(opsEqual),
    .strobes (strobes)
  );

  npc_datapath #(
    .XLEN    (XLEN),
    .IMM_W   (IMM_W),
    .JF_W    (JF_W),
    .RESET_PC(RESET_PC)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .branchImm (branchImm),
    .jumpField (jumpField),
    .jumpRegVal(jumpRegVal),
    .opsEqual  (opsEqual),
    .pcQ       (pcQ),
    .nextPc    (nextPc),
    .linkVal   (linkVal)
  );

  always_comb begin
    linkWe  = strobes.writeLink;
    linkReg = LINK_IDX;
  end

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int              XLEN      = 32,
  parameter int              IMM_W     = 16,
  parameter int              JF_W      = 26,
  parameter int              REG_IDX_W = 5,
  parameter logic [XLEN-1:0] RESET_PC  = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           flowKind,
  input logic [XLEN-1:0]      opA,
  input logic [XLEN-1:0]      opB,
  input logic [IMM_W-1:0]     branchImm,
  input logic [JF_W-1:0]      jumpField,
  input logic [XLEN-1:0]      jumpRegVal,
  input logic [XLEN-1:0]      pcQ,
  input logic [XLEN-1:0]      nextPc,
  input logic                 linkWe,
  input logic [REG_IDX_W-1:0] linkReg,
  input logic [XLEN-1:0]      linkVal
);

  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] seqAddr;
  logic [XLEN-1:0] offBytes;
  always_comb begin
    seqAddr  = pcQ + XLEN'(4);
    offBytes = {{EXT_W{branchImm[IMM_W-1]}}, branchImm, 2'b00};
  end

  AST_RESET_LOADS_START: assert property (@(posedge clk)
    rst |=> pcQ == RESET_PC); // R1

  AST_PC_TRACKS_NEXT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pcQ == $past(nextPc)); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd0 || flowKind == 3'd6 || flowKind == 3'd7) |-> nextPc == seqAddr); // R3

  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd1 && opA != opB) |-> nextPc == seqAddr); // R4

  AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd2 && opA != opB) |-> nextPc == seqAddr + offBytes); // R5

  AST_JUMP_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd3) |-> (nextPc[XLEN-1:JF_W+2] == seqAddr[XLEN-1:JF_W+2]
                            && nextPc[JF_W+1:2] == jumpField && nextPc[1:0] == 2'b00)); // R7

  AST_JAL_LINK: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd4) |-> (linkWe && linkVal == seqAddr && (&linkReg))); // R8

  AST_JREG_EXACT: assert property (@(posedge clk) disable iff (rst)
    (flowKind == 3'd5) |-> nextPc == jumpRegVal); // R9

  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> flowKind == 3'd4); // R10

endmodule

bind nextpc_unit nextpc_unit_chk #(
  .XLEN     (XLEN),
  .IMM_W    (IMM_W),
  .JF_W     (JF_W),
  .REG_IDX_W(REG_IDX_W),
  .RESET_PC (RESET_PC)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flowKind  (flowKind),
  .opA       (opA),
  .opB       (opB),
  .branchImm (branchImm),
  .jumpField (jumpField),
  .jumpRegVal(jumpRegVal),
  .pcQ       (pcQ),
  .nextPc    (nextPc),
  .linkWe    (linkWe),
  .linkReg   (linkReg),
  .linkVal   (linkVal)
);

// File: tb/nextpc_unit_tb_top.sv
module nextpc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  flowKind = 3'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] branchImm = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] jumpRegVal = '0;
  logic [31:0] pcQ;
  logic [31:0] nextPc;
  logic        linkWe;
  logic [4:0]  linkReg;
  logic [31:0] linkVal;

  int checksRun  = 0;
  int checksFail = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;

  nextpc_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .flowKind  (flowKind),
    .opA       (opA),
    .opB       (opB),
    .branchImm (branchImm),
    .jumpField (jumpField),
    .jumpRegVal(jumpRegVal),
    .pcQ       (pcQ),
    .nextPc    (nextPc),
    .linkWe    (linkWe),
    .linkReg   (linkReg),
    .linkVal   (linkVal)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checksRun++;
    if (!ok) begin
      checksFail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expTarget(input int kind, input logic [31:0] pc,
                                            input bit eq, input logic [15:0] imm,
                                            input logic [25:0] jf, input logic [31:0] rv);
    logic [31:0] seq;
    logic [31:0] br;
    seq = pc + 32'd4;
    br  = seq + ({{16{imm[15]}}, imm} * 32'd4);
    case (kind)
      1: return eq ? br : seq;
      2: return eq ? seq : br;
      3, 4: return {seq[31:28], jf, 2'b00};
      5: return rv;
      default: return seq;
    endcase
  endfunction

  task automatic runCase(input int kind, input logic [31:0] pcStart, input bit eq,
                         input logic [15:0] imm, input logic [25:0] jf,
                         input logic [31:0] rv);
    logic [31:0] exp;
    @(negedge clk);
    flowKind   = 3'd5;
    jumpRegVal = pcStart;
    @(negedge clk);
    check(pcQ == pcStart, "R9 load via jump-register", pcQ, pcStart);
    flowKind   = 3'(kind);
    opA        = pcStart ^ 32'h5A5A_0F0F;
    opB        = eq ? opA : (opA ^ (32'h1 << (kind * 5)));
    branchImm  = imm;
    jumpField  = jf;
    jumpRegVal = rv;
    exp = expTarget(kind, pcStart, eq, imm, jf, rv);
    #1;
    case (kind)
      1: check(nextPc == exp, "R4 R6 branch-if-equal", nextPc, exp);
      2: check(nextPc == exp, "R5 R6 branch-if-not-equal", nextPc, exp);
      3: check(nextPc == exp, "R7 jump", nextPc, exp);
      4: check(nextPc == exp, "R8 jump-and-link target", nextPc, exp);
      5: check(nextPc == exp, "R9 jump-register", nextPc, exp);
      default: check(nextPc == exp, "R3 sequential", nextPc, exp);
    endcase
    if (kind == 4) begin
      check(linkWe == 1'b1, "R8 link enable", 32'(linkWe), 32'd1);
      check(linkReg == 5'd31, "R8 link register", 32'(linkReg), 32'd31);
      check(linkVal == pcStart + 32'd4, "R8 link value", linkVal, pcStart + 32'd4);
    end else begin
      check(linkWe == 1'b0, "R10 no link", 32'(linkWe), 32'd0);
    end
    @(negedge clk);
    check(pcQ == exp, "R2 pc register load", pcQ, exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 150000) begin
        checksRun++;
        checksFail++;
        $display("FAIL watchdog actual=%08h expected=%08h", cycleCount, 150000);
        $display("%0d/%0d checks passed", checksRun - checksFail, checksRun);
        $finish;
      end
    end
  end

  initial begin : stimulus
    logic [31:0] pcSet [6];
    logic [15:0] immSet [6];
    logic [25:0] jfSet [3];
    pcSet  = '{32'h0000_0000, 32'h0000_0040, 32'h0FFF_FFFC,
               32'h7FFF_FFF0, 32'hFFFF_FFF8, 32'h1234_5678};
    immSet = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE};
    jfSet  = '{26'h000_0000, 26'h3FF_FFFF, 26'h123_4567};

    rst = 1'b1;
    flowKind = 3'd4;
    jumpField = 26'h3FF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check(pcQ == 32'h0, "R1 reset start address", pcQ, 32'h0);
    rst = 1'b0;
    flowKind = 3'd0;
    #1;
    check(nextPc == 32'h4, "R3 first sequential step", nextPc, 32'h4);

    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 6; p++) begin
        for (int e = 0; e < 2; e++) begin
          for (int i = 0; i < 6; i++) begin
            runCase(k, pcSet[p], e[0], immSet[i], jfSet[(p + i) % 3],
                    32'hC0DE_0000 ^ {pcSet[p][15:0], immSet[i]});
          end
        end
      end
    end

    @(negedge clk);
    flowKind   = 3'd5;
    jumpRegVal = 32'hDEAD_BEE4;
    @(negedge clk);
    rst = 1'b1;
    flowKind = 3'd3;
    @(negedge clk);
    check(pcQ == 32'h0, "R1 reset overrides jump", pcQ, 32'h0);
    rst = 1'b0;
    flowKind = 3'd0;
    @(negedge clk);
    check(pcQ == 32'h4, "R2 step after reset", pcQ, 32'h4);

    $display("%0d/%0d checks passed", checksRun - checksFail, checksRun);
    $finish;
  end

endmodule